// File: doc/BRIEF.md
# Six-Step Paired Deadtime Output Manager

This block turns one PWM source into six bridge gate signals for six-step commutation. The six outputs form three fixed pairs: outputs 0 and 1, outputs 2 and 3, and outputs 4 and 5. Each pair drives one half-bridge. Two per-channel words set the state of each output: inactive, held at a steady active level, or driven by PWM. The PWM source is either a compare output or a measurement-window signal, and a mode input picks between them.

Each pair has its own deadtime timer. When deadtime is enabled and exactly one channel of a pair is in the PWM state, that channel follows the source and the other channel of the pair takes the complement. Every turn-on edge on either output waits a programmable number of clock cycles, and every turn-off happens at once. If neither channel of a pair is enabled, both outputs of that pair stay off, so the floating phase can be sensed. A master enable and a per-output polarity word act on the final registered outputs.

Top module: `sixstep_dt_mgr`

## Requirements
- R1: The source is `cmp_pwm_i` when `win_sel_i`=0 and `win_pwm_i` when `win_sel_i`=1. When deadtime is not in use, a PWM-state output is active in the cycle after the next rising clock edge that samples a source of 1. The total latency is two edges from the input change to `gate_o`.
- R2: The state of channel c is encoded by two bits. If `ch_en_i[c]`=0, the channel is inactive. If `ch_en_i[c]`=1 and `ch_pwm_i[c]`=0, it is steadily active. If `ch_en_i[c]`=1 and `ch_pwm_i[c]`=1, it is PWM-driven. A change of these bits reaches `gate_o` after one edge.
- R3: Deadtime mode applies to a pair when `dt_en_i`=1 and exactly one channel of the pair is PWM-driven. In this mode the PWM channel is active only after the source has been sampled 1 on `dt_cycles_i`+1 consecutive edges. The partner channel is active only after the source has been sampled 0 on `dt_cycles_i`+1 consecutive edges. The partner's own state bits are ignored.
- R4: A source pulse or gap shorter than `dt_cycles_i`+1 samples leaves the output that would have turned on inactive for that whole pulse or gap.
- R5: When both channels of a pair are inactive, both outputs of the pair stay at their inactive level.
- R6: When both channels of a pair are PWM-driven, the configuration is illegal, and both outputs of that pair are inactive.
- R7: In deadtime mode the two outputs of a pair are never active in the same cycle.
- R8: When `out_en_i`=0, every output takes its inactive level one edge later.
- R9: The active level of output c is high when `pol_i[c]`=0 and low when `pol_i[c]`=1. The inactive level is the opposite value.
- R10: During reset `gate_o` is all zeros. After reset each timer behaves as if the source had been low for a long time.
- R11: Pairs are fixed as outputs {0,1}, {2,3} and {4,5}. The even channel is the first of each pair. Each pair is configured and timed independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_pwm_i | input | 1 | Compare-based PWM source |
| win_pwm_i | input | 1 | Measurement-window PWM source |
| win_sel_i | input | 1 | Source select (1 = window) |
| dt_en_i | input | 1 | Deadtime mode enable |
| dt_cycles_i | input | DT_W | Dead interval in clock cycles |
| ch_en_i | input | 2*NUM_PAIRS | Per-channel active bit |
| ch_pwm_i | input | 2*NUM_PAIRS | Per-channel PWM (1) / steady (0) bit |
| out_en_i | input | 1 | Master output enable |
| pol_i | input | 2*NUM_PAIRS | Per-output polarity (1 = active low) |
| gate_o | output | 2*NUM_PAIRS | Registered gate outputs |

## Verification
The hardest case to reach is a source pulse that ends before the dead interval has run out. The deadtime counter then restarts while the opposite output is still waiting to turn on, and both outputs must stay off. To reach it, the bench drives the source from a shift-register pattern whose run lengths range from one to several cycles. It also sweeps small dead intervals (0, 1 and 3), so runs shorter than, equal to and longer than the interval all occur within each configuration. A separate directed burst uses a two-cycle pulse against a four-cycle interval.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  typedef enum logic [1:0] {
    PM_STATIC = 2'd0,
    PM_DEAD   = 2'd1,
    PM_FAULT  = 2'd2
  } pair_mode_e;

  function automatic pair_mode_e classify(input logic pwm_a, input logic pwm_b,
                                          input logic dt_en);
    if (pwm_a && pwm_b)           return PM_FAULT;
    else if (dt_en && (pwm_a ^ pwm_b)) return PM_DEAD;
    else                          return PM_STATIC;
  endfunction
endpackage

// File: rtl/sixstep_dt_timer.sv
module sixstep_dt_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            lvl_o,
  output logic            hi_on_o,
  output logic            lo_on_o
);
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic            src_q;
  logic [DT_W-1:0] cnt_q;

  function automatic logic [DT_W-1:0] sat_inc(input logic [DT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic elapsed(input logic [DT_W-1:0] c, input logic [DT_W-1:0] d);
    return c >= d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      cnt_q <= CNT_MAX;
    end else if (src_i != src_q) begin
      src_q <= src_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= sat_inc(cnt_q);
    end
  end

  assign lvl_o   = src_q;
  assign hi_on_o = src_q  & elapsed(cnt_q, dt_i);
  assign lo_on_o = ~src_q & elapsed(cnt_q, dt_i);
endmodule

// File: rtl/sixstep_pair_steer.sv
module sixstep_pair_steer
  import sixstep_pkg::*;
(
  input  logic       en_a_i,
  input  logic       pwm_a_i,
  input  logic       en_b_i,
  input  logic       pwm_b_i,
  input  logic       dt_en_i,
  input  logic       lvl_i,
  input  logic       hi_on_i,
  input  logic       lo_on_i,
  output pair_mode_e mode_o,
  output logic [1:0] act_o
);
  logic a_pwm, b_pwm, a_hold, b_hold;

  assign a_pwm  = en_a_i & pwm_a_i;
  assign b_pwm  = en_b_i & pwm_b_i;
  assign a_hold = en_a_i & ~pwm_a_i;
  assign b_hold = en_b_i & ~pwm_b_i;
  assign mode_o = classify(a_pwm, b_pwm, dt_en_i);

  always_comb begin
    act_o = 2'b00;
    unique case (mode_o)
      PM_FAULT: act_o = 2'b00;
      PM_DEAD:  act_o = a_pwm ? {lo_on_i, hi_on_i} : {hi_on_i, lo_on_i};
      default: begin
        act_o[0] = a_hold | (a_pwm & lvl_i);
        act_o[1] = b_hold | (b_pwm & lvl_i);
      end
    endcase
  end
endmodule

// File: rtl/sixstep_dt_mgr.sv
module sixstep_dt_mgr
  import sixstep_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int DT_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmp_pwm_i,
  input  logic                   win_pwm_i,
  input  logic                   win_sel_i,
  input  logic                   dt_en_i,
  input  logic [DT_W-1:0]        dt_cycles_i,
  input  logic [2*NUM_PAIRS-1:0] ch_en_i,
  input  logic [2*NUM_PAIRS-1:0] ch_pwm_i,
  input  logic                   out_en_i,
  input  logic [2*NUM_PAIRS-1:0] pol_i,
  output logic [2*NUM_PAIRS-1:0] gate_o
);
  localparam int NCH = 2 * NUM_PAIRS;

  logic                 src_sel;
  logic [NCH-1:0]       pre_act;
  logic [NUM_PAIRS-1:0] pair_fault;
  logic [NUM_PAIRS-1:0] pair_dead;

  function automatic logic [NCH-1:0] drive_level(input logic en, input logic [NCH-1:0] act,
                                                 input logic [NCH-1:0] pol);
    return en ? (act ^ pol) : pol;
  endfunction

  assign src_sel = win_sel_i ? win_pwm_i : cmp_pwm_i;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic       lvl, hi_on, lo_on;
    pair_mode_e mode;

    sixstep_dt_timer #(.DT_W(DT_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_sel),
      .dt_i   (dt_cycles_i),
      .lvl_o  (lvl),
      .hi_on_o(hi_on),
      .lo_on_o(lo_on)
    );

    sixstep_pair_steer steer_i (
      .en_a_i (ch_en_i[2*p]),
      .pwm_a_i(ch_pwm_i[2*p]),
      .en_b_i (ch_en_i[2*p+1]),
      .pwm_b_i(ch_pwm_i[2*p+1]),
      .dt_en_i(dt_en_i),
      .lvl_i  (lvl),
      .hi_on_i(hi_on),
      .lo_on_i(lo_on),
      .mode_o (mode),
      .act_o  (pre_act[2*p+1:2*p])
    );

    assign pair_fault[p] = (mode == PM_FAULT);
    assign pair_dead[p]  = (mode == PM_DEAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_o <= '0;
    else        gate_o <= drive_level(out_en_i, pre_act, pol_i);
  end
endmodule

// File: rtl/sixstep_dt_mgr_chk.sv
module sixstep_dt_mgr_chk #(
  parameter int NUM_PAIRS = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_en_i,
  input logic [2*NUM_PAIRS-1:0] ch_en_i,
  input logic [2*NUM_PAIRS-1:0] pol_i,
  input logic [2*NUM_PAIRS-1:0] pre_act,
  input logic [NUM_PAIRS-1:0]   pair_fault,
  input logic [NUM_PAIRS-1:0]   pair_dead,
  input logic [2*NUM_PAIRS-1:0] gate_o
);
  p_master_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |=> gate_o == $past(pol_i));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pair_dead[p] |-> !(pre_act[2*p] && pre_act[2*p+1]));

    p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pair_fault[p] |=> gate_o[2*p+1:2*p] == $past(pol_i[2*p+1:2*p]));

    p_idle_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en_i[2*p] && !ch_en_i[2*p+1] && !pair_dead[p])
        |=> gate_o[2*p+1:2*p] == $past(pol_i[2*p+1:2*p]));

    p_gate_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_i |=> gate_o[2*p+1:2*p] == $past(pre_act[2*p+1:2*p] ^ pol_i[2*p+1:2*p]));
  end
endmodule

bind sixstep_dt_mgr sixstep_dt_mgr_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_en_i  (out_en_i),
  .ch_en_i   (ch_en_i),
  .pol_i     (pol_i),
  .pre_act   (pre_act),
  .pair_fault(pair_fault),
  .pair_dead (pair_dead),
  .gate_o    (gate_o)
);

// File: tb/sixstep_dt_mgr_tb.sv
module sixstep_dt_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NC = 2 * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_pwm = 1'b0, win_pwm = 1'b0, win_sel = 1'b0, dt_en = 1'b0, out_en = 1'b0;
  logic [7:0]    dt_cyc = 8'd0;
  logic [NC-1:0] ch_en = '0, ch_pwm = '0, pol = '0;
  logic [NC-1:0] gate;

  int n_chk = 0, n_bad = 0;
  bit model_on = 1'b0;
  logic [NC-1:0] exp_gate = '0;
  string exp_tag [NC];
  int run_hi = 0, run_lo = 1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  sixstep_dt_mgr #(.NUM_PAIRS(NP), .DT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_pwm_i(cmp_pwm), .win_pwm_i(win_pwm),
    .win_sel_i(win_sel), .dt_en_i(dt_en), .dt_cycles_i(dt_cyc),
    .ch_en_i(ch_en), .ch_pwm_i(ch_pwm), .out_en_i(out_en), .pol_i(pol), .gate_o(gate)
  );

  // Reference model built from R1..R11: run lengths of the sampled source.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_gate = '0;
      for (int c = 0; c < NC; c++) exp_tag[c] = "R10";
      run_hi = 0; run_lo = 1000;
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit ap, bp, on_hi, on_lo, lvl;
        bit [1:0] act;
        string tg;
        ap = ch_en[2*p] && ch_pwm[2*p];
        bp = ch_en[2*p+1] && ch_pwm[2*p+1];
        lvl = run_hi > 0;
        on_hi = run_hi >= int'(dt_cyc) + 1;
        on_lo = run_lo >= int'(dt_cyc) + 1;
        if (ap && bp) begin act = 2'b00; tg = "R6"; end
        else if (dt_en && (ap != bp)) begin
          act = ap ? {on_lo, on_hi} : {on_hi, on_lo}; tg = "R3";
        end else begin
          act[0] = ch_en[2*p] && (!ch_pwm[2*p] || lvl);
          act[1] = ch_en[2*p+1] && (!ch_pwm[2*p+1] || lvl);
          tg = (!ch_en[2*p] && !ch_en[2*p+1]) ? "R5" : (ap || bp) ? "R1" : "R2";
        end
        for (int k = 0; k < 2; k++) begin
          exp_gate[2*p+k] = out_en ? (act[k] ^ pol[2*p+k]) : pol[2*p+k];
          exp_tag[2*p+k] = out_en ? tg : "R8";
        end
      end
      if ((win_sel ? win_pwm : cmp_pwm) == 1'b1) begin
        run_hi = run_hi + 1; run_lo = 0;
      end else begin
        run_lo = run_lo + 1; run_hi = 0;
      end
      if (run_hi > 1000) run_hi = 1000;
      if (run_lo > 1000) run_lo = 1000;
    end
  end

  // Every output bit compared each cycle on the falling edge (R9, R11 per bit).
  always @(negedge clk) begin
    if (model_on) begin
      for (int c = 0; c < NC; c++) begin
        n_chk++;
        if (gate[c] !== exp_gate[c]) begin
          n_bad++;
          $display("FAIL %s (R9/R11 ch%0d) t=%0t: got %b expected %b",
                   exp_tag[c], c, $time, gate[c], exp_gate[c]);
        end
      end
      if (dt_en && out_en) begin
        for (int p = 0; p < NP; p++) begin
          bit ap, bp, a1, b1;
          ap = ch_en[2*p] && ch_pwm[2*p];
          bp = ch_en[2*p+1] && ch_pwm[2*p+1];
          a1 = gate[2*p] ^ pol[2*p];
          b1 = gate[2*p+1] ^ pol[2*p+1];
          if (ap != bp) begin
            n_chk++;
            if (a1 && b1) begin
              n_bad++;
              $display("FAIL R7 pair%0d: got both active 11, expected at most one", p);
            end
          end
        end
      end
    end
  end

  function automatic bit [2:0] state_of(int s);
    return (s == 0) ? 3'b000 : (s == 1) ? 3'b001 : 3'b011;
  endfunction

  task automatic set_cfg(int idx);
    for (int p = 0; p < NP; p++) begin
      int s_a, s_b;
      s_a = (idx + p) % 3;
      s_b = ((idx / 3) + 2*p) % 3;
      ch_en[2*p]    = state_of(s_a)[0];
      ch_pwm[2*p]   = state_of(s_a)[1];
      ch_en[2*p+1]  = state_of(s_b)[0];
      ch_pwm[2*p+1] = state_of(s_b)[1];
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    n_chk++;
    if (gate !== '0) begin
      n_bad++;
      $display("FAIL R10 reset: got %b expected 000000", gate);
    end
    #1 rst_n = 1'b1;
    model_on = 1'b1;
    out_en = 1'b1;

    begin
      logic [7:0] lfsr = 8'hA5;
      for (int cfg = 0; cfg < 9; cfg++)
        for (int de = 0; de < 2; de++)
          for (int di = 0; di < 3; di++)
            for (int ws = 0; ws < 2; ws++) begin
              @(negedge clk); #1;
              set_cfg(cfg);
              dt_en = de[0];
              dt_cyc = (di == 0) ? 8'd0 : (di == 1) ? 8'd1 : 8'd3;
              win_sel = ws[0];
              pol = 6'(cfg * 7 + di);
              for (int t = 0; t < 60; t++) begin
                @(negedge clk); #1;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                if (lfsr[1:0] != 2'b00) begin
                  if (ws == 1) win_pwm = ~win_pwm; else cmp_pwm = ~cmp_pwm;
                end
                if (ws == 1) cmp_pwm = lfsr[6]; else win_pwm = lfsr[6];
                out_en = !(t >= 50 && t < 53);
              end
            end
    end

    // R4: a 2-cycle pulse against a 4-cycle dead interval never turns the driven channel on.
    @(negedge clk); #1;
    win_sel = 1'b0; cmp_pwm = 1'b0; dt_en = 1'b1; dt_cyc = 8'd4; pol = '0; out_en = 1'b1;
    ch_en = 6'b000001; ch_pwm = 6'b000001;
    repeat (8) @(negedge clk);
    #1 cmp_pwm = 1'b1;
    begin
      bit seen = 1'b0;
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        if (gate[0]) seen = 1'b1;
        if (t == 1) #1 cmp_pwm = 1'b0;
      end
      n_chk++;
      if (seen) begin
        n_bad++;
        $display("FAIL R4 short pulse: got driven output active, expected inactive");
      end
    end
    repeat (2) @(negedge clk);

    model_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule